// File: doc/BRIEF.md
# Card Clock Divider with Staged Update Handshake

This block derives the clock that drives a memory card from the controller clock. A programmable even divider sets the ratio, an enable bit gates the output, and an optional low-power mode stops the clock whenever the command path is idle. Software writes a staging copy of the divider, source and enable settings through a small register port. Those writes have no effect on the output clock.

The staged settings take effect only when software writes an update-clock command, which has both the start flag and the update flag set. The block holds the command pending and reports it through the start flag. When the output is in a low phase and any requested wait for the data path is over, the block copies the staged values into the active set. It then clears the start flag, and software polls that flag as the acknowledge. The usual sequence is: gate the clock off, select source 0, write the divider, update, enable, update again.

Top module: `card_clk_div`

## Requirements
- R1: After reset `card_clk` is low, and every register reads 0: divider (address 0), source (address 1), enable (address 2) and command (address 3, start flag at bit 31).
- R2: With an active divider value N from 1 to 255, enabled and not in low-power mode, `card_clk` is high for N controller cycles and low for N cycles. The divider field is bits 7:0 of address 0.
- R3: A write to the divider, source or enable register updates only the staged value, which reads back at once. The output clock keeps its previous behaviour until an update completes.
- R4: A write to address 3 with bit 31 (start) and bit 21 (update) both set makes bit 31 read as 1 until the staged settings are applied, after which it reads 0. A command write without both bits is ignored, and bit 31 stays 0.
- R5: If the update command also has bit 13 set, the update stays pending, with bit 31 at 1 and the clock unchanged, for as long as `data_busy` is high.
- R6: A command written while an update is still pending is ignored, including its bit 13.
- R7: An active divider value of 0 passes the controller clock through undivided when the clock is enabled.
- R8: When the active enable bit (bit 0 of address 2) is 0, `card_clk` stays low.
- R9: With low-power gating active (bit 16 of address 2), `card_clk` stays low while `bus_active` is low. It rises at the first clock edge at which `bus_active` is high. A high phase that is in progress always completes its full N cycles.
- R10: New settings are applied only while `card_clk` is low. The output is low in the cycle in which the start flag clears, and no shortened high pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 divider, 1 source, 2 enable, 3 command) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| data_busy | input | 1 | Data transfer in progress; holds a waiting update |
| bus_active | input | 1 | Command path active; restarts a low-power-gated clock |
| card_clk | output | 1 | Generated card clock |

## Verification
A divider count or phase that goes wrong shows up as a high or low run of the wrong length on `card_clk`, within one output period. A lost or stuck pending flag shows up on the start bit within a few cycles of a command write or of `data_busy` falling. A settings copy made at the wrong moment shows up as `card_clk` being high in the cycle the start bit clears, or as a first pulse whose length belongs to neither the old setting nor the new one. The gating paths are checked cycle by cycle against `bus_active` and the enable bit.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DIV = 2'd0;
    localparam logic [ADDR_W-1:0] A_SRC = 2'd1;
    localparam logic [ADDR_W-1:0] A_ENA = 2'd2;
    localparam logic [ADDR_W-1:0] A_CMD = 2'd3;

    localparam int B_EN    = 0;
    localparam int B_LP    = 16;
    localparam int B_WAIT  = 13;
    localparam int B_UPD   = 21;
    localparam int B_START = 31;
endpackage

// File: rtl/ccd_regs.sv
module ccd_regs
    import ccd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SRC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              data_busy,
    input  logic              safe,
    output logic              load,
    output logic [DIV_W-1:0]  div_new,
    output logic [DIV_W-1:0]  div_a,
    output logic              en_a,
    output logic              lp_a,
    output logic              pend,
    output logic              wait_flag
);
    typedef struct packed {
        logic [DIV_W-1:0] div_s;
        logic [SRC_W-1:0] src_s;
        logic             en_s;
        logic             lp_s;
        logic             pend;
        logic             waitd;
        logic [DIV_W-1:0] div_a;
        logic             en_a;
        logic             lp_a;
    } st_t;

    st_t st_d, st_q;
    logic accept;

    assign accept = st_q.pend && (!st_q.waitd || !data_busy) && safe;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_DIV: st_d.div_s = wr_data[DIV_W-1:0];
                A_SRC: st_d.src_s = wr_data[SRC_W-1:0];
                A_ENA: begin
                    st_d.en_s = wr_data[B_EN];
                    st_d.lp_s = wr_data[B_LP];
                end
                default: begin
                    if (!st_q.pend && wr_data[B_START] && wr_data[B_UPD]) begin
                        st_d.pend  = 1'b1;
                        st_d.waitd = wr_data[B_WAIT];
                    end
                end
            endcase
        end
        if (accept) begin
            st_d.div_a = st_q.div_s;
            st_d.en_a  = st_q.en_s;
            st_d.lp_a  = st_q.lp_s;
            st_d.pend  = 1'b0;
            st_d.waitd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DIV: rd_data[DIV_W-1:0] = st_q.div_s;
            A_SRC: rd_data[SRC_W-1:0] = st_q.src_s;
            A_ENA: begin
                rd_data[B_EN] = st_q.en_s;
                rd_data[B_LP] = st_q.lp_s;
            end
            default: rd_data[B_START] = st_q.pend;
        endcase
    end

    assign load      = accept;
    assign div_new   = st_q.div_s;
    assign div_a     = st_q.div_a;
    assign en_a      = st_q.en_a;
    assign lp_a      = st_q.lp_a;
    assign pend      = st_q.pend;
    assign wait_flag = st_q.waitd;
endmodule

// File: rtl/ccd_divider.sv
module ccd_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_a,
    input  logic             en_a,
    input  logic             lp_a,
    input  logic             bus_active,
    input  logic             load,
    input  logic [DIV_W-1:0] div_new,
    output logic             safe,
    output logic             phase,
    output logic             card_clk
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             phase;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [DIV_W-1:0] term;
    logic running, bypass;
    logic gate_q, pass_q;

    assign bypass  = (div_a == '0);
    assign term    = bypass ? '0 : div_a - DIV_W'(1);
    assign running = en_a && (!lp_a || bus_active);
    assign safe    = bypass || (!dv_q.phase && dv_q.cnt == term);

    always_comb begin
        dv_d = dv_q;
        if (bypass) begin
            dv_d.cnt   = '0;
            dv_d.phase = 1'b0;
        end else if (dv_q.cnt == term) begin
            if (dv_q.phase) begin
                dv_d.phase = 1'b0;
                dv_d.cnt   = '0;
            end else if (running) begin
                dv_d.phase = 1'b1;
                dv_d.cnt   = '0;
            end
        end else begin
            dv_d.cnt = dv_q.cnt + DIV_W'(1);
        end
        if (load) begin
            dv_d.phase = 1'b0;
            dv_d.cnt   = (div_new == '0) ? '0 : div_new - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    // bypass gate and select change only while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            gate_q <= running && bypass;
            pass_q <= bypass;
        end
    end

    assign phase    = dv_q.phase;
    assign card_clk = pass_q ? (clk & gate_q) : dv_q.phase;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SRC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              data_busy,
    input  logic              bus_active,
    output logic              card_clk
);
    logic             safe, load, en_a, lp_a, pend, wait_flag, phase;
    logic [DIV_W-1:0] div_new, div_a;

    ccd_regs #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .data_busy(data_busy), .safe(safe), .load(load), .div_new(div_new),
        .div_a(div_a), .en_a(en_a), .lp_a(lp_a), .pend(pend),
        .wait_flag(wait_flag)
    );

    ccd_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_a(div_a), .en_a(en_a), .lp_a(lp_a),
        .bus_active(bus_active), .load(load), .div_new(div_new),
        .safe(safe), .phase(phase), .card_clk(card_clk)
    );
endmodule

// File: rtl/ccd_chk.sv
module ccd_chk
    import ccd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              data_busy,
    input logic              pend,
    input logic              wait_flag,
    input logic [DIV_W-1:0]  div_a,
    input logic              en_a,
    input logic              lp_a,
    input logic              phase
);
    logic [DIV_W:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (phase) hi_q <= hi_q + 1'b1;
        else            hi_q <= '0;
    end

    // R2
    hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase) |-> hi_q == {1'b0, div_a});

    // R3
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable({div_a, en_a, lp_a}));

    // R4
    pend_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(wr_en && wr_addr == A_CMD
                              && wr_data[B_START] && wr_data[B_UPD]));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && wait_flag && data_busy) |=> pend);

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_a && !phase) |=> !phase);

    // R10
    low_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_a) |-> (!phase && !$past(phase)));
endmodule

bind card_clk_div ccd_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .data_busy(data_busy), .pend(pend),
    .wait_flag(wait_flag), .div_a(div_a), .en_a(en_a), .lp_a(lp_a),
    .phase(phase)
);

// File: tb/card_clk_div_bench.sv
`timescale 1ns/1ps
module card_clk_div_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        data_busy = 1'b0;
    logic        bus_active = 1'b0;
    logic        card_clk;
    int          n_run = 0;
    int          n_fail = 0;

    localparam logic [31:0] UPD      = 32'h8020_0000;
    localparam logic [31:0] UPD_WAIT = 32'h8020_2000;

    always #2.5 clk = ~clk;

    card_clk_div u_card_clk_div (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .data_busy(data_busy), .bus_active(bus_active), .card_clk(card_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a; #0.1; d = rd_data;
    endtask

    task automatic wait_clear(input string req);
        logic [31:0] v;
        int n = 0;
        rd(2'd3, v);
        while (v[31] && n < 2000) begin tick(); n++; rd(2'd3, v); end
        chk(!v[31], req, int'(v[31]), 0);
    endtask

    task automatic update(input string req);
        logic [31:0] v;
        wr(2'd3, UPD);
        rd(2'd3, v);
        chk(v[31], req, int'(v[31]), 1);
        wait_clear(req);
    endtask

    task automatic measure(input int n, input string req);
        int hi = 0, lo = 0, g = 0;
        while (card_clk && g < 2000) begin tick(); g++; end
        while (!card_clk && g < 4000) begin tick(); g++; end
        while (card_clk && hi < 1000) begin tick(); hi++; end
        while (!card_clk && lo < 1000) begin tick(); lo++; end
        chk(hi == n, {req, " high"}, hi, n);
        chk(lo == n, {req, " low"}, lo, n);
    endtask

    task automatic stay_low(input int n, input string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin tick(); if (card_clk) highs++; end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(card_clk == 1'b0, "R1 clk", int'(card_clk), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 reg", int'(v), 0);
        end
    endtask

    task automatic t_program();
        logic [31:0] v;
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'd2);
        update("R4 first update");
        wr(2'd2, 32'h1);
        rd(2'd2, v);
        chk(v == 32'h1, "R3 enable readback", int'(v), 1);
        update("R4 second update");
        measure(2, "R2 n=2");
    endtask

    task automatic t_edges();
        wr(2'd0, 32'd255); update("R4 n=255"); measure(255, "R2 n=255");
        wr(2'd0, 32'd1);   update("R4 n=1");   measure(1, "R2 n=1");
    endtask

    task automatic t_staged();
        logic [31:0] v;
        wr(2'd0, 32'd4);
        rd(2'd0, v);
        chk(v == 32'd4, "R3 div readback", int'(v), 4);
        measure(1, "R3 staged no effect");
        update("R4 apply 4");
        measure(4, "R2 n=4");
    endtask

    task automatic t_partial();
        logic [31:0] v;
        wr(2'd0, 32'd6);
        wr(2'd3, 32'h8000_0000);
        rd(2'd3, v);
        chk(!v[31], "R4 start without update bit", int'(v[31]), 0);
        wr(2'd3, 32'h0020_0000);
        rd(2'd3, v);
        chk(!v[31], "R4 update without start bit", int'(v[31]), 0);
        measure(4, "R4 partial command ignored");
    endtask

    task automatic t_wait();
        logic [31:0] v;
        data_busy = 1'b1;
        wr(2'd3, UPD_WAIT);
        for (int i = 0; i < 20; i++) tick();
        rd(2'd3, v);
        chk(v[31], "R5 pending while busy", int'(v[31]), 1);
        measure(4, "R5 clock unchanged");
        wr(2'd3, UPD);
        for (int i = 0; i < 5; i++) tick();
        rd(2'd3, v);
        chk(v[31], "R6 second command ignored", int'(v[31]), 1);
        measure(4, "R6 clock unchanged");
        data_busy = 1'b0;
        wait_clear("R5 clears after busy");
        chk(card_clk == 1'b0, "R10 low at apply", int'(card_clk), 0);
        measure(6, "R10 first pulse full");
    endtask

    task automatic t_bypass();
        int bad = 0;
        wr(2'd0, 32'd0); update("R4 bypass");
        for (int i = 0; i < 3; i++) tick();
        for (int i = 0; i < 10; i++) begin
            if (card_clk !== 1'b1) bad++;
            @(negedge clk); #1;
            if (card_clk !== 1'b0) bad++;
            tick();
        end
        chk(bad == 0, "R7 pass through", bad, 0);
    endtask

    task automatic t_disable();
        wr(2'd2, 32'h0); update("R4 disable");
        stay_low(40, "R8 disabled low");
        wr(2'd0, 32'd3); update("R4 n=3 disabled");
        stay_low(40, "R8 disabled divided low");
    endtask

    task automatic t_lowpower();
        int hi = 0;
        wr(2'd2, 32'h0001_0001); update("R4 low power");
        stay_low(20, "R9 idle low");
        bus_active = 1'b1;
        tick();
        chk(card_clk == 1'b1, "R9 restart one cycle", int'(card_clk), 1);
        bus_active = 1'b0;
        while (card_clk && hi < 100) begin hi++; tick(); end
        chk(hi == 3, "R9 full high phase", hi, 3);
        stay_low(20, "R9 stops again");
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_program();
        t_edges();
        t_staged();
        t_partial();
        t_wait();
        t_bypass();
        t_disable();
        t_lowpower();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule